// File: doc/BRIEF.md
# Receive Inline Metadata Stripper

This block sits in a receive datapath between the Ethernet MAC and the host interface. An upstream crypto engine may insert an 8-byte metadata header into each frame it has processed. The header is placed directly after the 14-byte Ethernet header and is marked by a dedicated ethertype. The block inspects every incoming frame for that marker. When the marker is present, it reads a one-byte syndrome and a 32-bit security-association handle, removes the 8 header bytes, and puts the frame's real ethertype back after the MAC addresses. The decoded result is presented on sideband outputs alongside the forwarded frame.

Frames without the marker, and frames too short to hold it, are passed through byte for byte. A marked frame whose syndrome is neither "decrypted" nor "authentication failed" is consumed and discarded in full, and a saturating drop counter records it. Both the input and the output are 64-bit AXI4-Stream with tkeep, tlast and backpressure. Byte n of a frame travels in lane n mod 8, at tdata[8*(n mod 8) +: 8], and tkeep is contiguous from lane 0.

Top module: `rx_meta_strip`

## Requirements
- R1: A frame is treated as carrying metadata only when byte 12 is 0x8C, byte 13 is 0xE4, and the frame is at least 22 bytes long.
- R2: A frame without the marker leaves the block with identical bytes and length, with m_offload low, m_status 2'b00 and m_sa_handle zero.
- R3: A frame shorter than 22 bytes is forwarded unchanged with m_offload low, even if bytes 12 and 13 hold the marker.
- R4: Syndrome 0x11 (byte 14) forwards the frame with m_offload high, m_status 2'b01, and m_sa_handle equal to bytes 16 to 19 read big-endian, byte 16 being the most significant.
- R5: Syndrome 0x12 forwards the frame with m_offload high and m_status 2'b10; the handle is decoded as in R4.
- R6: Any other syndrome in a marked frame drops the whole frame, with no output beat, and adds one to drop_count, which saturates at all ones.
- R7: A forwarded marked frame is 8 bytes shorter. Its output is input bytes 0 to 11, then input bytes 20 and 21 (the real ethertype), then input bytes 22 onward, and the final beat's tkeep marks the shortened length.
- R8: m_offload, m_status and m_sa_handle are valid with the first output beat of a frame and do not change until that frame's tlast is accepted; m_offload high always pairs with status 01 or 10, m_offload low with status 00 and handle zero.
- R9: While m_tvalid is high and m_tready is low, the output beat is held unchanged; output backpressure and input gaps neither lose nor duplicate bytes.
- R10: A synchronous active-low reset discards any partly received header, clears drop_count, and leaves m_tvalid low and s_tready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 64 | Input stream data |
| s_tkeep | input | 8 | Input byte enables |
| s_tlast | input | 1 | Input end of frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block accepts input beat |
| m_tdata | output | 64 | Output stream data |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Output end of frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts output beat |
| m_offload | output | 1 | Frame had metadata and was stripped |
| m_status | output | 2 | 00 none, 01 decrypt success, 10 authentication failed |
| m_sa_handle | output | 32 | Decoded security-association handle |
| drop_count | output | 32 | Saturating count of frames dropped for unknown syndrome |

## Verification
On every cycle the checker confirms that no output beat appears while a dropped frame drains, that a stalled output beat holds, that the sideband stays fixed from one accepted beat to the next within a frame and always carries a legal status and handle pairing, and that drop_count never moves by more than one. The exact byte layout after stripping, the handle byte order, the short-frame and non-marker pass-through, and the tkeep of shortened final beats only show up in the bench's frame scenarios. Counter saturation and reset in the middle of a header are also shown only by the bench, which compares whole frames against a model built from the requirements.

// File: rtl/rx_meta_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the inline metadata stripper.
// Assumes a 64-bit stream: the 8 stripped bytes equal one beat.
package rx_meta_pkg;
    localparam logic [7:0] TAG_HI     = 8'h8C;  // byte 12 of a marked frame
    localparam logic [7:0] TAG_LO     = 8'hE4;  // byte 13 of a marked frame
    localparam logic [7:0] SYN_DECRYPT = 8'h11;
    localparam logic [7:0] SYN_AUTHBAD = 8'h12;
    localparam int         HDR_BEATS  = 3;      // beats held before a decision

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_DECRYPT = 2'b01,
        RES_AUTHBAD = 2'b10
    } result_e;

    typedef enum logic [2:0] {
        P_BEAT0,
        P_BEAT1,
        P_BEAT2,
        P_EMIT,
        P_BODY,
        P_DRAIN
    } phase_e;
endpackage

// File: rtl/rx_meta_decode.sv
`timescale 1ns/1ps
// Combinational decode of the metadata header.
// Inputs are frame bytes 12..14 (from the second beat) and bytes 16..19
// (from the third beat). Assumes the caller has checked the frame length.
module rx_meta_decode
    import rx_meta_pkg::*;
(
    input  logic [23:0] tag_bytes,   // bytes 12,13,14 in lanes 0,1,2
    input  logic [31:0] handle_bytes,// bytes 16..19 in lanes 0..3
    input  logic        long_enough,
    output logic        is_meta,
    output logic        known_syn,
    output result_e     result,
    output logic [31:0] handle
);
    logic [7:0] syn;

    // Match the marker and classify the syndrome.
    always_comb begin
        syn       = tag_bytes[23:16];
        is_meta   = long_enough && (tag_bytes[7:0] == TAG_HI) && (tag_bytes[15:8] == TAG_LO);
        known_syn = 1'b1;
        result    = RES_NONE;
        if (syn == SYN_DECRYPT)      result = RES_DECRYPT;
        else if (syn == SYN_AUTHBAD) result = RES_AUTHBAD;
        else                         known_syn = 1'b0;
        // big-endian: first byte on the wire is the most significant
        handle = {handle_bytes[7:0], handle_bytes[15:8], handle_bytes[23:16], handle_bytes[31:24]};
    end
endmodule

// File: rtl/rx_meta_sat_ctr.sv
`timescale 1ns/1ps
// Saturating event counter. Holds at all ones once reached.
module rx_meta_sat_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count events, stopping at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (inc && (count != '1))   count <= count + 1'b1;
    end
endmodule

// File: rtl/rx_meta_strip.sv
`timescale 1ns/1ps
// Receive-side metadata stripper.
// Buffers the first three beats of each frame, decides whether the frame
// carries the inline header, then replays the buffered beats (with the
// header removed when present) and streams the rest of the frame straight
// through. Assumes DATA_W = 64, contiguous tkeep, and an upstream that holds
// its beat stable while s_tready is low.
module rx_meta_strip
    import rx_meta_pkg::*;
#(
    parameter int  DATA_W     = 64,
    parameter int  DROP_CNT_W = 32,
    localparam int KEEP_W     = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     s_tdata,
    input  logic [KEEP_W-1:0]     s_tkeep,
    input  logic                  s_tlast,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    output logic [DATA_W-1:0]     m_tdata,
    output logic [KEEP_W-1:0]     m_tkeep,
    output logic                  m_tlast,
    output logic                  m_tvalid,
    input  logic                  m_tready,
    output logic                  m_offload,
    output logic [1:0]            m_status,
    output logic [31:0]           m_sa_handle,
    output logic [DROP_CNT_W-1:0] drop_count
);
    localparam int HALF_W = DATA_W / 2;
    localparam int HALF_K = KEEP_W / 2;
    localparam int IDX_W  = $clog2(HDR_BEATS);

    phase_e              phase;
    logic [DATA_W-1:0]   hold_data [HDR_BEATS];
    logic [KEEP_W-1:0]   hold_keep [HDR_BEATS];
    logic                hold_last [HDR_BEATS];
    logic [IDX_W-1:0]    emit_idx;
    logic [IDX_W-1:0]    emit_end;
    logic                sb_off;
    result_e             sb_res;
    logic [31:0]         sb_handle;

    logic                is_meta, known_syn, long_enough, in_take, drop_pulse, draining;
    result_e             dec_res;
    logic [31:0]         dec_handle;

    // A 22-byte frame ends in the third beat with lane 5 as its last byte.
    assign long_enough = !(s_tlast && !s_tkeep[5]);
    assign in_take     = s_tvalid && s_tready;
    assign drop_pulse  = (phase == P_BEAT2) && in_take && is_meta && !known_syn;
    assign draining    = (phase == P_DRAIN);

    rx_meta_decode u_dec (
        .tag_bytes    (hold_data[1][HALF_W+23:HALF_W]),
        .handle_bytes (s_tdata[31:0]),
        .long_enough  (long_enough),
        .is_meta      (is_meta),
        .known_syn    (known_syn),
        .result       (dec_res),
        .handle       (dec_handle)
    );

    rx_meta_sat_ctr #(.CNT_W(DROP_CNT_W)) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_pulse),
        .count (drop_count)
    );

    // Per-slot capture of the first beats, one generate branch per slot.
    for (genvar g = 0; g < HDR_BEATS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_data[g] <= '0;
                hold_keep[g] <= '0;
                hold_last[g] <= 1'b0;
            end else if (in_take && (phase == P_BEAT0) && (g == 0)) begin
                hold_data[g] <= s_tdata;
                hold_keep[g] <= s_tkeep;
                hold_last[g] <= s_tlast;
            end else if (in_take && (phase == P_BEAT1) && (g == 1)) begin
                hold_data[g] <= s_tdata;
                hold_keep[g] <= s_tkeep;
                hold_last[g] <= s_tlast;
            end else if (in_take && (phase == P_BEAT2) && (g == 1) && is_meta) begin
                // merged beat: addresses 8..11, then real ethertype onward
                hold_data[g] <= {s_tdata[DATA_W-1:HALF_W], hold_data[g][HALF_W-1:0]};
                hold_keep[g] <= {s_tkeep[KEEP_W-1:HALF_K], hold_keep[g][HALF_K-1:0]};
                hold_last[g] <= s_tlast;
            end else if (in_take && (phase == P_BEAT2) && (g == 2)) begin
                hold_data[g] <= s_tdata;
                hold_keep[g] <= s_tkeep;
                hold_last[g] <= s_tlast;
            end
        end
    end

    // Frame phase sequencing and replay index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= P_BEAT0;
            emit_idx <= '0;
            emit_end <= '0;
        end else begin
            case (phase)
                P_BEAT0: if (in_take) begin
                    emit_idx <= '0;
                    emit_end <= IDX_W'(0);
                    phase    <= s_tlast ? P_EMIT : P_BEAT1;
                end
                P_BEAT1: if (in_take) begin
                    emit_end <= IDX_W'(1);
                    phase    <= s_tlast ? P_EMIT : P_BEAT2;
                end
                P_BEAT2: if (in_take) begin
                    if (is_meta && !known_syn) begin
                        phase <= s_tlast ? P_BEAT0 : P_DRAIN;
                    end else begin
                        emit_end <= is_meta ? IDX_W'(1) : IDX_W'(2);
                        phase    <= P_EMIT;
                    end
                end
                P_EMIT: if (m_tready) begin
                    if (emit_idx == emit_end) begin
                        emit_idx <= '0;
                        phase    <= hold_last[emit_idx] ? P_BEAT0 : P_BODY;
                    end else begin
                        emit_idx <= emit_idx + 1'b1;
                    end
                end
                P_BODY:  if (in_take && s_tlast) phase <= P_BEAT0;
                P_DRAIN: if (in_take && s_tlast) phase <= P_BEAT0;
                default: phase <= P_BEAT0;
            endcase
        end
    end

    // Sideband result, latched when a forwarded frame is classified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_off    <= 1'b0;
            sb_res    <= RES_NONE;
            sb_handle <= '0;
        end else if (in_take && (((phase == P_BEAT0 || phase == P_BEAT1) && s_tlast) ||
                                 ((phase == P_BEAT2) && !is_meta))) begin
            sb_off    <= 1'b0;
            sb_res    <= RES_NONE;
            sb_handle <= '0;
        end else if (in_take && (phase == P_BEAT2) && is_meta && known_syn) begin
            sb_off    <= 1'b1;
            sb_res    <= dec_res;
            sb_handle <= dec_handle;
        end
    end

    // Output selection: replay buffered beats, then cut through.
    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tdata  = hold_data[emit_idx];
        m_tkeep  = hold_keep[emit_idx];
        m_tlast  = hold_last[emit_idx];
        case (phase)
            P_BEAT0, P_BEAT1, P_BEAT2, P_DRAIN: s_tready = 1'b1;
            P_EMIT:  m_tvalid = 1'b1;
            P_BODY: begin
                s_tready = m_tready;
                m_tvalid = s_tvalid;
                m_tdata  = s_tdata;
                m_tkeep  = s_tkeep;
                m_tlast  = s_tlast;
            end
            default: ;
        endcase
    end

    assign m_offload   = sb_off;
    assign m_status    = sb_res;
    assign m_sa_handle = sb_handle;
endmodule

// File: rtl/rx_meta_strip_chk.sv
`timescale 1ns/1ps
// Protocol and sideband checker for rx_meta_strip, attached by bind.
module rx_meta_strip_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [DATA_W/8-1:0] m_tkeep,
    input logic              m_tlast,
    input logic              m_offload,
    input logic [1:0]        m_status,
    input logic [31:0]       m_sa_handle,
    input logic [CNT_W-1:0]  drop_count,
    input logic              draining
);
    // R6: a frame being discarded never produces an output beat
    a_r6_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> !m_tvalid);

    // R6: the drop counter moves by zero or one per cycle
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((drop_count == $past(drop_count)) ||
                  (drop_count == CNT_W'($past(drop_count) + 1'b1))));

    // R9: a stalled output beat is held
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
                                     $stable(m_tkeep) && $stable(m_tlast)));

    // R8: sideband fixed between beats of one frame
    a_r8_side_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !m_tlast) |=> ($stable(m_offload) &&
                                                $stable(m_status) && $stable(m_sa_handle)));

    // R8: legal pairing of offload flag, status and handle
    a_r8_side_legal: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_offload ? (m_status == 2'b01 || m_status == 2'b10)
                                : (m_status == 2'b00 && m_sa_handle == 32'h0)));

    // R10: first cycle after reset shows an idle, cleared block
    a_r10_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!m_tvalid && drop_count == '0));
endmodule

bind rx_meta_strip rx_meta_strip_chk #(.DATA_W(DATA_W), .CNT_W(DROP_CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_tvalid    (m_tvalid),
    .m_tready    (m_tready),
    .m_tdata     (m_tdata),
    .m_tkeep     (m_tkeep),
    .m_tlast     (m_tlast),
    .m_offload   (m_offload),
    .m_status    (m_status),
    .m_sa_handle (m_sa_handle),
    .drop_count  (drop_count),
    .draining    (draining)
);

// File: tb/tb_rx_meta_strip.sv
`timescale 1ns/1ps
// Frame-level bench: a vector table of frames walked by one loop,
// then directed tests for saturation and reset inside a header.
module tb_rx_meta_strip;
    localparam int CW = 2;  // small counter so saturation is reachable

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   s_tdata = '0;
    logic [7:0]    s_tkeep = '0;
    logic          s_tlast = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [63:0]   m_tdata;
    logic [7:0]    m_tkeep;
    logic          m_tlast;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic          m_offload;
    logic [1:0]    m_status;
    logic [31:0]   m_sa_handle;
    logic [CW-1:0] drop_count;

    rx_meta_strip #(.DATA_W(64), .DROP_CNT_W(CW)) dut (.*);

    always #2 clk = ~clk;  // 250 MHz

    // {length, ethertype, syndrome, handle, backpressure mode}
    localparam int NV = 15;
    localparam logic [65:0] VEC [NV] = '{
        {8'd64,  16'h0800, 8'h00, 32'h00000000, 2'd0},
        {8'd64,  16'h8CE4, 8'h11, 32'hDEADBEEF, 2'd0},
        {8'd60,  16'h8CE4, 8'h12, 32'h01020304, 2'd1},
        {8'd70,  16'h8CE4, 8'h33, 32'h11111111, 2'd2},
        {8'd21,  16'h8CE4, 8'h11, 32'hAAAAAAAA, 2'd0},
        {8'd22,  16'h8CE4, 8'h11, 32'hCAFEF00D, 2'd3},
        {8'd23,  16'h8CE4, 8'h12, 32'h80000001, 2'd0},
        {8'd24,  16'h8CE4, 8'h11, 32'h12345678, 2'd1},
        {8'd8,   16'h0800, 8'h00, 32'h00000000, 2'd0},
        {8'd13,  16'h86DD, 8'h00, 32'h00000000, 2'd2},
        {8'd16,  16'h8CE4, 8'h11, 32'h55555555, 2'd0},
        {8'd100, 16'h8CE4, 8'h00, 32'h22222222, 2'd3},
        {8'd17,  16'h8CE4, 8'h11, 32'h66666666, 2'd1},
        {8'd200, 16'h8CE4, 8'h11, 32'h0BADC0DE, 2'd3},
        {8'd23,  16'h8CE4, 8'hFF, 32'h77777777, 2'd0}
    };

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] fin  [256];
    logic [7:0] gout [256];
    logic [7:0] eout [256];
    int  gout_len = 0;
    int  frames_out = 0;
    bit  first_beat = 1'b1;
    bit  sb_bad = 1'b0;
    logic       cap_off;
    logic [1:0] cap_st;
    logic [31:0] cap_h;
    bit  out_stall = 1'b0;
    int  exp_drops = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Output side: drive ready at the falling edge, record accepted beats.
    always @(negedge clk) begin
        m_tready = !(out_stall && ((cyc % 3) == 1));
        #1;
        if (rst_n && m_tvalid && m_tready) begin
            if (first_beat) begin
                cap_off = m_offload; cap_st = m_status; cap_h = m_sa_handle;
            end else if (cap_off !== m_offload || cap_st !== m_status || cap_h !== m_sa_handle) begin
                sb_bad = 1'b1;
            end
            for (int l = 0; l < 8; l++)
                if (m_tkeep[l]) begin gout[gout_len] = m_tdata[8*l +: 8]; gout_len++; end
            if (m_tlast) begin frames_out++; first_beat = 1'b1; end
            else first_beat = 1'b0;
        end
    end

    // Input side: send up to max_beats beats of fin[0..len-1].
    task automatic send_frame(input int len, input bit gaps, input int max_beats);
        for (int b = 0; b * 8 < len && b < max_beats; b++) begin
            if (gaps && (b % 2 == 1)) begin @(negedge clk); s_tvalid = 1'b0; end
            @(negedge clk);
            s_tvalid = 1'b1;
            s_tlast  = ((b + 1) * 8 >= len);
            for (int l = 0; l < 8; l++) begin
                s_tdata[8*l +: 8] = (b*8 + l < len) ? fin[b*8 + l] : 8'h00;
                s_tkeep[l]        = (b*8 + l < len);
            end
            forever begin
                #0.5;
                if (s_tready) begin @(posedge clk); break; end
                @(negedge clk);
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic build_frame(input int vi);
        logic [7:0]  ln = VEC[vi][65:58];
        logic [15:0] et = VEC[vi][57:42];
        logic [7:0]  sy = VEC[vi][41:34];
        logic [31:0] hd = VEC[vi][33:2];
        for (int i = 0; i < 256; i++) fin[i] = 8'((i * 7 + vi * 13 + 5) & 255);
        fin[12] = et[15:8]; fin[13] = et[7:0];
        fin[14] = sy; fin[15] = 8'h00;
        fin[16] = hd[31:24]; fin[17] = hd[23:16]; fin[18] = hd[15:8]; fin[19] = hd[7:0];
        fin[20] = 8'h08; fin[21] = 8'h00;
        if (ln < 8'd22) fin[20] = 8'(vi);
    endtask

    task automatic run_vec(input int vi);
        int len = int'(VEC[vi][65:58]);
        logic [15:0] et = VEC[vi][57:42];
        logic [7:0]  sy = VEC[vi][41:34];
        logic [31:0] hd = VEC[vi][33:2];
        logic [1:0]  bp = VEC[vi][1:0];
        bit meta = (len >= 22) && (et == 16'h8CE4);
        bit drop = meta && (sy != 8'h11) && (sy != 8'h12);
        int elen = 0;
        int f0;
        int mism = -1;
        logic [1:0] est = 2'b00;
        string rq;
        build_frame(vi);
        if (meta && !drop) begin
            for (int i = 0; i < 12; i++) begin eout[elen] = fin[i]; elen++; end
            for (int i = 20; i < len; i++) begin eout[elen] = fin[i]; elen++; end
            est = (sy == 8'h11) ? 2'b01 : 2'b10;
            rq  = (sy == 8'h11) ? "R4/R7" : "R5/R7";
        end else if (!drop) begin
            for (int i = 0; i < len; i++) begin eout[elen] = fin[i]; elen++; end
            rq = (len < 22) ? "R3" : "R2";
        end else rq = "R6";
        if (drop) exp_drops = (exp_drops < 3) ? exp_drops + 1 : 3;
        gout_len = 0; sb_bad = 1'b0;
        f0 = frames_out;
        out_stall = bp[0];
        send_frame(len, bp[1], 1000);
        if (!drop) begin
            for (int w = 0; w < 400 && frames_out == f0; w++) @(negedge clk);
        end else repeat (12) @(negedge clk);
        out_stall = 1'b0;
        // R1: marker detection decides whether a frame is output at all
        check(frames_out == f0 + (drop ? 0 : 1), drop ? "R6" : "R1", "frames out", frames_out - f0, drop ? 0 : 1);
        check(gout_len == elen, rq, "length", gout_len, elen);
        for (int i = 0; i < elen && i < gout_len; i++) if (mism < 0 && gout[i] !== eout[i]) mism = i;
        check(mism < 0, rq, "byte mismatch at index", mism, -1);
        if (!drop) begin
            check(cap_off == meta, rq, "offload", cap_off, meta);
            check(cap_st == est, rq, "status", cap_st, est);
            check(cap_h == (meta ? hd : 32'h0), rq, "handle", cap_h, meta ? hd : 32'h0);
            check(!sb_bad, "R8", "sideband changed within frame", sb_bad, 0);
        end
        check(drop_count == CW'(exp_drops), "R6", "drop_count", drop_count, exp_drops);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(m_tvalid == 1'b0, "R10", "m_tvalid in reset", m_tvalid, 0);
        check(drop_count == '0, "R10", "drop_count in reset", drop_count, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check(s_tready == 1'b1, "R10", "s_tready after reset", s_tready, 1);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R6: counter has reached its maximum and must hold there
        run_vec(3);
        check(drop_count == 2'b11, "R6", "saturated drop_count", drop_count, 3);

        // R10: reset with two header beats buffered, then a clean frame
        build_frame(1);
        send_frame(64, 1'b0, 2);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(m_tvalid == 1'b0, "R10", "m_tvalid after mid-header reset", m_tvalid, 0);
        check(drop_count == '0, "R10", "drop_count cleared", drop_count, 0);
        @(negedge clk); rst_n = 1'b1;
        exp_drops = 0;
        first_beat = 1'b1;
        run_vec(1);  // R10 and R7: no leftover header bytes appear

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule